// File: doc/BRIEF.md
# Dual-Level Overcurrent Protection Monitor

This block guards a synchronous step-down power stage against overload. While the low-side switch conducts, the voltage drop across it is converted to a millivolt code. The block compares that code with a limit that the user programs, and with a second, higher limit that the block derives from the first. A slow overload must be seen in several switching periods in a row before the stage is shut down. A hard short, which drives the code above the higher limit, shuts the stage down at once. Once asserted, the shutdown output holds until the block is reset, which models a full supply cycle.

The user limit is not written by software. Right after reset, a timed setting window runs while external circuitry produces a pin voltage that stands for the limit. When the window ends, that voltage code is captured and saturated into the legal range. If the pin voltage reaches the clamp level first, the window closes early and the largest limit is used. No comparison is made before capture has finished.

All voltage codes are unsigned with 1 LSB = 1 mV.

Top module: `dual_ocp_guard`

## Requirements
- R1: While reset is held and after it is released, until capture: settingDone is 0, tripOff is 0 and thresh1 reads TH_MAX (550).
- R2: Without a clamp, the pin code is captured on the WIN_CYCLES-th rising clock edge after reset release, and settingDone rises on that same edge.
- R3: If pinCode is at least CLAMP_LVL (600) during the window, capture takes place on the next edge with thresh1 = TH_MAX, ending the window early.
- R4: The captured thresh1 is the pin code saturated into the range TH_MIN (50) to TH_MAX (550).
- R5: thresh2 always equals thresh1 + floor(thresh1 / 2).
- R6: phaseCode is ignored, and no trip can occur, unless settingDone is 1 and lowSideOn is 1.
- R7: A first-level event is phaseCode strictly greater than thresh1 at any cycle of a switching period, and a cycleStrobe pulse closes the period (that cycle included). The period that completes EVT_COUNT (4) consecutive event periods sets tripOff on its strobe edge.
- R8: A switching period closed with no first-level event clears the consecutive-period count to zero.
- R9: phaseCode strictly greater than thresh2 sets tripOff on the next clock edge, with no strobe needed.
- R10: tripOff, settingDone and thresh1 hold until reset once they are set, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (supply cycle) |
| lowSideOn | input | 1 | Low-side switch conducting |
| cycleStrobe | input | 1 | One-cycle pulse closing a switching period |
| phaseCode | input | CODE_W | Phase-node drop code, mV |
| pinCode | input | CODE_W | Setting-pin voltage code, mV |
| thresh1 | output | CODE_W | Captured first-level limit |
| thresh2 | output | CODE_W+1 | Derived second-level limit |
| settingDone | output | 1 | Limit captured, monitoring enabled |
| tripOff | output | 1 | Latched shutdown of both switches |

## Verification
The bench builds the block with WIN_CYCLES = 20 in place of the default, which is millisecond scale, and keeps CODE_W = 10, EVT_COUNT = 4 and the default limits. With a short window, the bench can run through a full timed capture, an early clamp exit and the saturation at both range ends, each after its own reset. The window edge can be sampled on the exact cycle. The event count of four keeps the three-and-reset and four-in-a-row patterns short enough for one vector table.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load thresh1 this edge
    logic forceMax;  // load the largest limit instead of the pin code
  } ocpStrobe_t;
endpackage

// File: rtl/ocp_dpath.sv
module ocp_dpath
  import ocp_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int TH_MIN    = 50,
  parameter int TH_MAX    = 550,
  parameter int CLAMP_LVL = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  ocpStrobe_t        stb,
  input  logic [CODE_W-1:0] pinCode,
  input  logic [CODE_W-1:0] phaseCode,
  output logic [CODE_W-1:0] thresh1,
  output logic [CODE_W:0]   thresh2,
  output logic              clampHit,
  output logic              l1Over,
  output logic              l2Over
);
  localparam logic [CODE_W-1:0] MinC   = CODE_W'(TH_MIN);
  localparam logic [CODE_W-1:0] MaxC   = CODE_W'(TH_MAX);
  localparam logic [CODE_W-1:0] ClampC = CODE_W'(CLAMP_LVL);

  logic [CODE_W-1:0] satCode;

  always_comb begin
    if (pinCode < MinC)      satCode = MinC;
    else if (pinCode > MaxC) satCode = MaxC;
    else                     satCode = pinCode;
  end

  assign clampHit = (pinCode >= ClampC);

  always_ff @(posedge clk) begin
    if (!rstN)            thresh1 <= MaxC;
    else if (stb.capture) thresh1 <= stb.forceMax ? MaxC : satCode;
  end

  // 1.5x by shift and add
  assign thresh2 = {1'b0, thresh1} + {2'b00, thresh1[CODE_W-1:1]};
  assign l1Over  = (phaseCode > thresh1);
  assign l2Over  = ({1'b0, phaseCode} > thresh2);

  // R4: captured limit always within range
  a_r4_range: assert property (@(posedge clk) disable iff (!rstN)
    (thresh1 >= MinC) && (thresh1 <= MaxC));
  // R10: limit changes only on a capture strobe
  a_r10_thresh_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(thresh1));
  // R3: clamp capture loads the largest limit
  a_r3_clamp_max: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && stb.forceMax) |=> (thresh1 == MaxC));
endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl
  import ocp_pkg::*;
#(
  parameter int WIN_CYCLES = 500000,
  parameter int EVT_COUNT  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowSideOn,
  input  logic       cycleStrobe,
  input  logic       clampHit,
  input  logic       l1Over,
  input  logic       l2Over,
  output ocpStrobe_t stb,
  output logic       settingDone,
  output logic       tripOff
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam int RUN_W = $clog2(EVT_COUNT + 1);
  localparam logic [WIN_W-1:0] WinLast = WIN_W'(WIN_CYCLES - 1);
  localparam logic [RUN_W-1:0] RunLast = RUN_W'(EVT_COUNT - 1);

  logic [WIN_W-1:0] winCnt;
  logic [RUN_W-1:0] runCnt;
  logic evtSeen, armed, l1Now, l2Now, hit;

  assign stb.capture  = !settingDone && (clampHit || winCnt == WinLast);
  assign stb.forceMax = clampHit;

  assign armed = settingDone && !tripOff;
  assign l1Now = armed && lowSideOn && l1Over;
  assign l2Now = armed && lowSideOn && l2Over;
  assign hit   = evtSeen || l1Now;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt      <= '0;
      settingDone <= 1'b0;
    end else if (!settingDone) begin
      winCnt <= winCnt + 1'b1;
      if (stb.capture) settingDone <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtSeen <= 1'b0;
      runCnt  <= '0;
      tripOff <= 1'b0;
    end else if (armed) begin
      if (cycleStrobe) begin
        evtSeen <= 1'b0;
        if (hit) begin
          if (runCnt == RunLast) begin
            tripOff <= 1'b1;
            runCnt  <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end else begin
          runCnt <= '0;
        end
      end else if (l1Now) begin
        evtSeen <= 1'b1;
      end
      if (l2Now) tripOff <= 1'b1;
    end
  end

  // R10: shutdown is sticky
  a_r10_trip_sticky: assert property (@(posedge clk) disable iff (!rstN)
    tripOff |=> tripOff);
  // R2: setting completes once and stays
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    settingDone |=> settingDone);
  // R6: no trip while the limit is still being set
  a_r6_no_early_trip: assert property (@(posedge clk) disable iff (!rstN)
    !settingDone |=> !tripOff);
  // R8: a quiet period clears the run
  a_r8_run_clear: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cycleStrobe && !hit) |=> (runCnt == '0));
  // R9: second-level excess trips on the next edge
  a_r9_fast_trip: assert property (@(posedge clk) disable iff (!rstN)
    l2Now |=> tripOff);
endmodule

// File: rtl/dual_ocp_guard.sv
module dual_ocp_guard
  import ocp_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int TH_MIN     = 50,
  parameter int TH_MAX     = 550,
  parameter int CLAMP_LVL  = 600,
  parameter int WIN_CYCLES = 500000,
  parameter int EVT_COUNT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowSideOn,
  input  logic              cycleStrobe,
  input  logic [CODE_W-1:0] phaseCode,
  input  logic [CODE_W-1:0] pinCode,
  output logic [CODE_W-1:0] thresh1,
  output logic [CODE_W:0]   thresh2,
  output logic              settingDone,
  output logic              tripOff
);
  ocpStrobe_t stb;
  logic clampHit, l1Over, l2Over;

  ocp_ctrl #(
    .WIN_CYCLES(WIN_CYCLES),
    .EVT_COUNT (EVT_COUNT)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .lowSideOn  (lowSideOn),
    .cycleStrobe(cycleStrobe),
    .clampHit   (clampHit),
    .l1Over     (l1Over),
    .l2Over     (l2Over),
    .stb        (stb),
    .settingDone(settingDone),
    .tripOff    (tripOff)
  );

  ocp_dpath #(
    .CODE_W   (CODE_W),
    .TH_MIN   (TH_MIN),
    .TH_MAX   (TH_MAX),
    .CLAMP_LVL(CLAMP_LVL)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pinCode  (pinCode),
    .phaseCode(phaseCode),
    .thresh1  (thresh1),
    .thresh2  (thresh2),
    .clampHit (clampHit),
    .l1Over   (l1Over),
    .l2Over   (l2Over)
  );
endmodule

// File: tb/dual_ocp_guard_tb_top.sv
module dual_ocp_guard_tb_top;
  localparam int CW  = 10;
  localparam int WIN = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowSideOn = 1'b0;
  logic cycleStrobe = 1'b0;
  logic [CW-1:0] phaseCode = '0;
  logic [CW-1:0] pinCode = '0;
  logic [CW-1:0] thresh1;
  logic [CW:0]   thresh2;
  logic settingDone, tripOff;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_ocp_guard #(.CODE_W(CW), .WIN_CYCLES(WIN), .EVT_COUNT(4)) dut_i (
    .clk(clk), .rstN(rstN), .lowSideOn(lowSideOn), .cycleStrobe(cycleStrobe),
    .phaseCode(phaseCode), .pinCode(pinCode), .thresh1(thresh1),
    .thresh2(thresh2), .settingDone(settingDone), .tripOff(tripOff)
  );

  typedef struct packed {
    logic ls;
    logic st;
    logic [CW-1:0] ph;
    logic expTrip;
  } vec_t;

  // limit 200, second level 300
  localparam vec_t VECS [12] = '{
    '{1'b1, 1'b1, 10'd250, 1'b0},  // R7 run 1
    '{1'b1, 1'b1, 10'd250, 1'b0},  // run 2
    '{1'b1, 1'b1, 10'd250, 1'b0},  // run 3
    '{1'b1, 1'b1, 10'd150, 1'b0},  // R8 quiet period clears run
    '{1'b0, 1'b1, 10'd400, 1'b0},  // R6 low side off: ignored
    '{1'b1, 1'b0, 10'd250, 1'b0},  // R7 event mid-period
    '{1'b0, 1'b1, 10'd0,   1'b0},  // period closes with event: run 1
    '{1'b1, 1'b1, 10'd200, 1'b0},  // R7 equal is not above: run 0
    '{1'b1, 1'b1, 10'd300, 1'b0},  // R9 equal to thresh2 no trip, run 1
    '{1'b1, 1'b1, 10'd300, 1'b0},  // run 2
    '{1'b1, 1'b1, 10'd300, 1'b0},  // run 3
    '{1'b1, 1'b1, 10'd201, 1'b1}   // R7 fourth in a row trips
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic drive(input logic ls, input logic st, input int ph);
    lowSideOn   = ls;
    cycleStrobe = st;
    phaseCode   = CW'(ph);
  endtask

  // reset, check R1, then walk the window; busy inputs during setting probe R6
  task automatic doReset(input int pin, input bit early);
    @(negedge clk);
    rstN = 1'b0;
    pinCode = CW'(pin);
    drive(1'b1, 1'b1, 1023);
    repeat (2) @(negedge clk);
    chk("R1 done in reset", int'(settingDone), 0);
    chk("R1 trip in reset", int'(tripOff), 0);
    chk("R1 thresh1 in reset", int'(thresh1), 550);
    rstN = 1'b1;
    if (early) begin
      @(negedge clk);
      chk("R3 early done", int'(settingDone), 1);
    end else begin
      repeat (WIN - 1) @(negedge clk);
      chk("R2 not done before window end", int'(settingDone), 0);
      chk("R1 thresh1 before capture", int'(thresh1), 550);
      @(negedge clk);
      chk("R2 done at window end", int'(settingDone), 1);
    end
    chk("R6 no trip during setting", int'(tripOff), 0);
    drive(1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    doReset(200, 1'b0);
    chk("R4 captured in range", int'(thresh1), 200);
    chk("R5 thresh2 of 200", int'(thresh2), 300);

    foreach (VECS[i]) begin
      drive(VECS[i].ls, VECS[i].st, int'(VECS[i].ph));
      @(negedge clk);
      chk($sformatf("R7/R8 vector %0d trip", i), int'(tripOff), int'(VECS[i].expTrip));
    end
    drive(1'b0, 1'b0, 0);

    // R10 trip sticky and no recapture
    pinCode = CW'(600);
    drive(1'b0, 1'b1, 0);
    repeat (3) @(negedge clk);
    chk("R10 trip held", int'(tripOff), 1);
    chk("R10 thresh1 held", int'(thresh1), 200);

    // R9 immediate second-level trip
    doReset(200, 1'b0);
    drive(1'b1, 1'b0, 301);
    @(negedge clk);
    chk("R9 fast trip", int'(tripOff), 1);
    drive(1'b0, 1'b0, 0);

    // R3 clamp ends window early
    doReset(600, 1'b1);
    chk("R3 thresh1 max", int'(thresh1), 550);
    chk("R5 thresh2 of 550", int'(thresh2), 825);

    // R4 saturation low and high
    doReset(20, 1'b0);
    chk("R4 low saturate", int'(thresh1), 50);
    chk("R5 thresh2 of 50", int'(thresh2), 75);
    doReset(580, 1'b0);
    chk("R4 high saturate", int'(thresh1), 550);

    // R5 odd limit rounds down the half
    doReset(201, 1'b0);
    chk("R5 thresh2 of 201", int'(thresh2), 301);
    // R10 no recapture after done
    pinCode = CW'(700);
    repeat (3) @(negedge clk);
    chk("R10 no recapture", int'(thresh1), 201);

    summary();
  end
endmodule